// File: doc/BRIEF.md
# Serial block readout interface

This block is the read side of a three-wire serial slave that hands decoded radio data blocks to a host controller. While the enable line is low, the host clocks an 8-bit address into the block. When the address selects readout mode and the enable then goes high, the block puts one 32-bit word on the serial data output for every 32 clock pulses. Each word carries one buffered data block. The block keeps sending words for as long as the enable stays high.

The three pins come from another clock domain. They are synchronized to the system clock and their edges are detected there. The block sits in front of a first-word-fall-through block buffer. It takes the head entry's status flags and 16-bit payload, adds a fixed validity nibble at the front, and pulses a pop when the host has taken a word. When the buffer is empty, filler words of all zeros are sent. A word that was cut off partway through is sent again at the next readout. A word that was cut off with only its last bit unsent counts as delivered. The serial clock may idle at either level.

Top module: `rdo_serial_readout`

## Requirements
- R1: Readout starts only when the 8 bits clocked in on rising serial-clock edges while enable was low, first bit first, are 0,0,1,1,0,1,1,0 (value 8'h36 with the first bit as MSB). The enable must then rise.
- R2: Each word goes out MSB first as follows.
  - Bits 31..28 are the nibble 1010.
  - Bit 27 is offset-found, bits 26..24 are the offset code, bit 23 is more-available, and bits 22..21 are the fill level.
  - Bit 20 is the ARI flag, bit 19 is the lock flag, and bits 18..16 are the correction code.
  - Bits 15..0 are the payload.
- R3: Several words can be read in one enable-high period. Each completed buffered word produces exactly one single-cycle pop, and the next word comes from the new buffer head.
- R4: When the buffer is empty, the word sent is all zeros and no pop is issued.
- R5: If the enable falls after fewer than 31 bits of a word were clocked, there is no pop, and the next readout sends the same word again from its first bit.
- R6: If the enable falls after exactly 31 bits of a buffered word were clocked, that word is popped and the next readout starts with the following entry.
- R7: Readout works with the serial clock idling low and with it idling high. When the clock idles high, the first falling edge after the enable rises does not advance the bit.
- R8: Any other address leaves the data output at 0 for the whole enable-high period and issues no pop.
- R9: The read-done output pulses for one cycle when the enable falls, if at least one buffered word was consumed in that period. It stays low otherwise.
- R10: After reset, the data output, pop and read-done are all 0.
- R11: During readout, the data output changes only after falling serial-clock edges, so it is stable while the clock is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_i | input | 1 | Serial enable pin (asynchronous) |
| sck_i | input | 1 | Serial clock pin (asynchronous) |
| sdi_i | input | 1 | Serial data in pin (asynchronous) |
| sdo_o | output | 1 | Serial data out, registered |
| buf_valid_i | input | 1 | Buffer head entry is present |
| buf_ofs_found_i | input | 1 | Head entry: offset word found |
| buf_ofs_kind_i | input | 3 | Head entry: offset code |
| buf_more_i | input | 1 | Head entry: more data follows |
| buf_fill_i | input | 2 | Head entry: fill level code |
| buf_ari_i | input | 1 | Head entry: ARI flag |
| buf_lock_i | input | 1 | Head entry: lock flag |
| buf_fix_i | input | 3 | Head entry: correction code |
| buf_data_i | input | DATA_W | Head entry payload |
| buf_pop_o | output | 1 | One-cycle pop of the head entry |
| rd_done_o | output | 1 | One-cycle pulse when a readout period that consumed data ends |

## Verification
- **Full reads.** Words are read whole with both clock idle levels. Single words and back-to-back bursts are checked against a buffer model. This separates a correct field layout from a wrong one, and shows the head advances on each pop.
- **Cut-off reads.** Readouts are stopped after 10 bits and after 31 bits. These show the resend case and the taken-as-delivered case, observed through the pop count and through which word comes next.
- **Empty buffer and wrong address.** Reads of an empty buffer and a session with a wrong address check that zeros are sent and no entry is lost.
- **Output stability.** The output is sampled again in the middle of each high clock phase to catch any change that is not tied to a falling edge.

// File: rtl/rdo_pkg.sv
package rdo_pkg;

  // Fixed validity nibble at the front of every non-empty word
  localparam logic [3:0] VALID_NIBBLE = 4'b1010;

  // Flag fields of one buffered block, MSB first in send order
  typedef struct packed {
    logic       ofs_found;
    logic [2:0] ofs_kind;
    logic       more_avail;
    logic [1:0] fill_level;
    logic       ari_seen;
    logic       locked;
    logic [2:0] fix_code;
  } rdo_flags_t;

  localparam int FLAGS_W = $bits(rdo_flags_t);
  localparam int HDR_W   = 4 + FLAGS_W;

endpackage

// File: rtl/rdo_pin_sync.sv
module rdo_pin_sync #(
  parameter int N      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] pin,
  output logic [N-1:0] lvl
);

  // One synchronizer chain per asynchronous pin
  for (genvar g = 0; g < N; g++) begin : g_pin
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk) begin
      if (rst) chain_q <= '0;
      else     chain_q <= {chain_q[STAGES-2:0], pin[g]};
    end
    assign lvl[g] = chain_q[STAGES-1];
  end

endmodule

// File: rtl/rdo_addr_cap.sv
module rdo_addr_cap #(
  parameter int                ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] OUT_ADDR = 8'h36
) (
  input  logic clk,
  input  logic rst,
  input  logic ce_lvl,
  input  logic sck_lvl,
  input  logic sdi_lvl,
  output logic hit
);

  localparam int               ACNT_W    = $clog2(ADDR_W + 1);
  localparam logic [ACNT_W-1:0] ACNT_FULL = ACNT_W'(ADDR_W);

  logic              ce_prev_q, sck_prev_q;
  logic [ADDR_W-1:0] shreg_q;
  logic [ACNT_W-1:0] cnt_q;
  logic              sck_rise, ce_fall;

  assign sck_rise = sck_lvl & ~sck_prev_q;
  assign ce_fall  = ~ce_lvl & ce_prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ce_prev_q  <= 1'b0;
      sck_prev_q <= 1'b0;
      shreg_q    <= '0;
      cnt_q      <= '0;
    end else begin
      ce_prev_q  <= ce_lvl;
      sck_prev_q <= sck_lvl;
      if (ce_fall) begin
        cnt_q <= '0;
      end else if (!ce_lvl && sck_rise) begin
        // first bit ends up at the MSB
        shreg_q <= {shreg_q[ADDR_W-2:0], sdi_lvl};
        if (cnt_q != ACNT_FULL) cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // Needs a full address since the enable last fell
  assign hit = (cnt_q == ACNT_FULL) && (shreg_q == OUT_ADDR);

  // R1: bit counter never runs past the address length
  p_addr_cnt_r1: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= ACNT_FULL);

endmodule

// File: rtl/rdo_word_tx.sv
module rdo_word_tx
  import rdo_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int RELOAD_LAT = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce_lvl,
  input  logic              sck_lvl,
  input  logic              addr_hit,
  input  logic              head_valid,
  input  rdo_flags_t        head_flags,
  input  logic [DATA_W-1:0] head_data,
  output logic              sdo,
  output logic              pop,
  output logic              done
);

  localparam int               W         = HDR_W + DATA_W;
  localparam int               CNT_W     = $clog2(W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL  = CNT_W'(W);
  localparam logic [CNT_W-1:0] CNT_ALMOST = CNT_W'(W - 1);

  logic                  ce_prev_q, sck_prev_q;
  logic                  ce_rise, ce_fall, sck_rise, sck_fall;
  logic                  sending_q, real_q, any_q, pend_q;
  logic                  sdo_q, pop_q, done_q;
  logic [W-1:0]          word_q, head_word;
  logic [CNT_W-1:0]      cnt_q;
  logic [RELOAD_LAT-1:0] reload_q;
  logic                  load_now, reloading;

  assign ce_rise  = ce_lvl & ~ce_prev_q;
  assign ce_fall  = ~ce_lvl & ce_prev_q;
  assign sck_rise = sck_lvl & ~sck_prev_q;
  assign sck_fall = ~sck_lvl & sck_prev_q;

  assign head_word = head_valid ? {VALID_NIBBLE, head_flags, head_data} : '0;
  assign load_now  = sending_q & reload_q[RELOAD_LAT-1];
  assign reloading = |reload_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ce_prev_q  <= 1'b0;
      sck_prev_q <= 1'b0;
      sending_q  <= 1'b0;
      real_q     <= 1'b0;
      any_q      <= 1'b0;
      pend_q     <= 1'b0;
      sdo_q      <= 1'b0;
      pop_q      <= 1'b0;
      done_q     <= 1'b0;
      word_q     <= '0;
      cnt_q      <= '0;
      reload_q   <= '0;
    end else begin
      ce_prev_q  <= ce_lvl;
      sck_prev_q <= sck_lvl;
      pop_q      <= 1'b0;
      done_q     <= 1'b0;
      reload_q   <= {reload_q[RELOAD_LAT-2:0], 1'b0};
      if (ce_rise) begin
        if (addr_hit) begin
          sending_q <= 1'b1;
          word_q    <= head_word;
          sdo_q     <= head_word[W-1];
          real_q    <= head_valid;
          cnt_q     <= '0;
          pend_q    <= 1'b0;
          any_q     <= 1'b0;
        end
      end else if (ce_fall) begin
        if (sending_q) begin
          // word taken once its final bit at most is missing
          if (real_q && !reloading && cnt_q >= CNT_ALMOST) begin
            pop_q  <= 1'b1;
            done_q <= 1'b1;
          end else if (any_q) begin
            done_q <= 1'b1;
          end
        end
        sending_q <= 1'b0;
        sdo_q     <= 1'b0;
        reload_q  <= '0;
        cnt_q     <= '0;
        pend_q    <= 1'b0;
      end else if (sending_q) begin
        if (load_now) begin
          word_q <= head_word;
          sdo_q  <= head_word[W-1];
          real_q <= head_valid;
          cnt_q  <= '0;
          pend_q <= 1'b0;
        end else if (!reloading) begin
          if (sck_rise && cnt_q != CNT_FULL) begin
            cnt_q  <= cnt_q + 1'b1;
            pend_q <= 1'b1;
          end else if (sck_fall && pend_q) begin
            pend_q <= 1'b0;
            if (cnt_q == CNT_FULL) begin
              pop_q    <= real_q;
              any_q    <= any_q | real_q;
              reload_q <= {reload_q[RELOAD_LAT-2:0], 1'b1};
            end else begin
              word_q <= {word_q[W-2:0], 1'b0};
              sdo_q  <= word_q[W-2];
            end
          end
        end
      end
    end
  end

  assign sdo  = sdo_q;
  assign pop  = pop_q;
  assign done = done_q;

  // R4: a pop only ever retires a word that came from the buffer
  p_pop_real_r4: assert property (@(posedge clk) disable iff (rst)
    pop_q |-> $past(real_q));

  // R8: no pop outside an accepted readout period
  p_pop_in_session_r8: assert property (@(posedge clk) disable iff (rst)
    pop_q |-> $past(sending_q));

  // R3: each pop lasts a single cycle
  p_pop_single_r3: assert property (@(posedge clk) disable iff (rst)
    pop_q |=> !pop_q);

  // R9: read-done follows an enable fall
  p_done_on_cefall_r9: assert property (@(posedge clk) disable iff (rst)
    done_q |-> $past(ce_fall));

  // R11: output moves only on a falling clock edge or a word load
  p_sdo_stable_r11: assert property (@(posedge clk) disable iff (rst)
    (sending_q && $past(sending_q) && !$past(sck_fall) && !$past(load_now))
      |-> $stable(sdo_q));

endmodule

// File: rtl/rdo_serial_readout.sv
module rdo_serial_readout
  import rdo_pkg::*;
#(
  parameter int               DATA_W     = 16,
  parameter int               ADDR_W     = 8,
  parameter logic [ADDR_W-1:0] OUT_ADDR  = 8'h36,
  parameter int               SYNC_STAGES = 2,
  parameter int               RELOAD_LAT = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce_i,
  input  logic              sck_i,
  input  logic              sdi_i,
  output logic              sdo_o,
  input  logic              buf_valid_i,
  input  logic              buf_ofs_found_i,
  input  logic [2:0]        buf_ofs_kind_i,
  input  logic              buf_more_i,
  input  logic [1:0]        buf_fill_i,
  input  logic              buf_ari_i,
  input  logic              buf_lock_i,
  input  logic [2:0]        buf_fix_i,
  input  logic [DATA_W-1:0] buf_data_i,
  output logic              buf_pop_o,
  output logic              rd_done_o
);

  localparam int PINS = 3;

  logic [PINS-1:0] pin_lvl;
  logic            ce_lvl, sck_lvl, sdi_lvl;
  logic            addr_hit;
  rdo_flags_t      head_flags;

  rdo_pin_sync #(.N(PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .pin ({sdi_i, sck_i, ce_i}),
    .lvl (pin_lvl)
  );

  assign ce_lvl  = pin_lvl[0];
  assign sck_lvl = pin_lvl[1];
  assign sdi_lvl = pin_lvl[2];

  rdo_addr_cap #(.ADDR_W(ADDR_W), .OUT_ADDR(OUT_ADDR)) u_addr (
    .clk     (clk),
    .rst     (rst),
    .ce_lvl  (ce_lvl),
    .sck_lvl (sck_lvl),
    .sdi_lvl (sdi_lvl),
    .hit     (addr_hit)
  );

  assign head_flags = '{ofs_found:  buf_ofs_found_i,
                        ofs_kind:   buf_ofs_kind_i,
                        more_avail: buf_more_i,
                        fill_level: buf_fill_i,
                        ari_seen:   buf_ari_i,
                        locked:     buf_lock_i,
                        fix_code:   buf_fix_i};

  rdo_word_tx #(.DATA_W(DATA_W), .RELOAD_LAT(RELOAD_LAT)) u_tx (
    .clk        (clk),
    .rst        (rst),
    .ce_lvl     (ce_lvl),
    .sck_lvl    (sck_lvl),
    .addr_hit   (addr_hit),
    .head_valid (buf_valid_i),
    .head_flags (head_flags),
    .head_data  (buf_data_i),
    .sdo        (sdo_o),
    .pop        (buf_pop_o),
    .done       (rd_done_o)
  );

endmodule

// File: tb/rdo_serial_readout_tb_top.sv
`timescale 1ns/1ps
module rdo_serial_readout_tb_top;

  localparam int T = 10; // system clocks per serial half period

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic ce = 1'b0, sck = 1'b0, sdi = 1'b0;
  logic sdo, pop, done;
  logic hv = 1'b0;
  logic [27:0] head_e = '0;

  logic [27:0] ent_q[$];
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic [31:0] rx_q[$];
  event        rx_ev;

  int n_cmp = 0, n_bad = 0, pop_cnt = 0, done_cnt = 0, stab_err = 0, exp_done = 0;
  logic [31:0] cur;

  rdo_serial_readout dut_i (
    .clk(clk), .rst(rst), .ce_i(ce), .sck_i(sck), .sdi_i(sdi), .sdo_o(sdo),
    .buf_valid_i(hv), .buf_ofs_found_i(head_e[27]), .buf_ofs_kind_i(head_e[26:24]),
    .buf_more_i(head_e[23]), .buf_fill_i(head_e[22:21]), .buf_ari_i(head_e[20]),
    .buf_lock_i(head_e[19]), .buf_fix_i(head_e[18:16]), .buf_data_i(head_e[15:0]),
    .buf_pop_o(pop), .rd_done_o(done)
  );

  // Buffer model: first-word-fall-through, advances on pop
  always @(posedge clk) begin
    if (!rst) begin
      if (pop) begin
        if (ent_q.size() > 0) void'(ent_q.pop_front());
        pop_cnt++;
      end
      if (done) done_cnt++;
    end
    hv     <= (ent_q.size() > 0);
    head_e <= (ent_q.size() > 0) ? ent_q[0] : '0;
  end

  function automatic logic [31:0] expw(logic [27:0] e);
    return {4'b1010, e};
  endfunction

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  // Monitor: compare each received word with the scoreboard
  initial begin
    forever begin
      @(rx_ev);
      while (rx_q.size() > 0) begin
        logic [31:0] got;
        got = rx_q.pop_front();
        if (exp_q.size() == 0) chk("R3 unexpected word", got, 32'hxxxx_xxxx);
        else chk(tag_q.pop_front(), got, exp_q.pop_front());
      end
    end
  end

  task automatic hd(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_word(logic [31:0] w, string tag);
    exp_q.push_back(w);
    tag_q.push_back(tag);
  endtask

  // One enable period: address phase, then nbits clocked out
  task automatic session(logic [7:0] addr, bit idle_hi, int nbits, bit score);
    sck = idle_hi;
    hd(T);
    for (int i = 7; i >= 0; i--) begin
      sdi = addr[i];
      sck = 1'b0; hd(T);
      sck = 1'b1; hd(T);
      if (!idle_hi) sck = 1'b0;
    end
    hd(T);
    sdi = 1'b0;
    ce = 1'b1;
    hd(T);
    if (idle_hi) begin sck = 1'b0; hd(T); end
    cur = '0;
    for (int i = 0; i < nbits; i++) begin
      logic b;
      b = sdo;
      cur = {cur[30:0], b};
      sck = 1'b1;
      hd(T/2);
      if (sdo !== b) stab_err++;
      hd(T - T/2);
      if (!idle_hi || i < nbits - 1) begin sck = 1'b0; hd(T); end
      if ((i % 32) == 31 && score) begin
        rx_q.push_back(cur);
        -> rx_ev;
      end
    end
    ce = 1'b0;
    hd(2*T);
  endtask

  localparam logic [27:0] EA = {1'b1,3'b101,1'b1,2'b10,1'b0,1'b1,3'b011,16'hC3A5};
  localparam logic [27:0] EB = {1'b0,3'b010,1'b0,2'b01,1'b1,1'b0,3'b100,16'h5A0F};
  localparam logic [27:0] EC = {1'b1,3'b111,1'b1,2'b11,1'b1,1'b1,3'b111,16'hFFFF};
  localparam logic [27:0] ED = {1'b0,3'b001,1'b0,2'b00,1'b0,1'b1,3'b000,16'h8001};
  localparam logic [27:0] EE = {1'b1,3'b100,1'b0,2'b11,1'b0,1'b0,3'b010,16'h1234};
  localparam logic [27:0] EF = {1'b0,3'b011,1'b1,2'b00,1'b1,1'b1,3'b001,16'hABCD};
  localparam logic [27:0] EG = {1'b1,3'b000,1'b1,2'b01,1'b0,1'b1,3'b101,16'h0F0F};

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog (all requirements): actual timeout expected finish");
    summary();
    $finish;
  end

  initial begin
    hd(4);
    rst = 1'b0;
    hd(2);
    // R10 reset state
    chk("R10 sdo after reset", {31'd0, sdo}, 32'd0);
    chk("R10 pop/done after reset", {30'd0, pop, done}, 32'd0);

    // R1/R2: single word, clock idles low
    ent_q.push_back(EA); ent_q.push_back(EB); ent_q.push_back(EC);
    hd(4);
    expect_word(expw(EA), "R1 R2 word A idle-low");
    session(8'h36, 1'b0, 32, 1'b1);
    exp_done++;
    chk("R3 pops after A", pop_cnt, 1);
    chk("R9 done after A", done_cnt, exp_done);

    // R3/R7: two words back to back, clock idles high
    expect_word(expw(EB), "R7 word B idle-high");
    expect_word(expw(EC), "R3 word C back-to-back");
    session(8'h36, 1'b1, 64, 1'b1);
    exp_done++;
    chk("R3 pops after B C", pop_cnt, 3);
    chk("R9 done after B C", done_cnt, exp_done);

    // R4: empty buffer gives zeros, no pop, no done
    expect_word(32'd0, "R4 empty word");
    session(8'h36, 1'b0, 32, 1'b1);
    chk("R4 no pop when empty", pop_cnt, 3);
    chk("R9 no done when nothing consumed", done_cnt, exp_done);

    // R5: cut after 10 bits, then resend whole word
    ent_q.push_back(ED); ent_q.push_back(EE); ent_q.push_back(EF);
    hd(4);
    session(8'h36, 1'b0, 10, 1'b0);
    chk("R5 partial bits of D", {22'd0, cur[9:0]}, {22'd0, expw(ED)[31:22]});
    chk("R5 no pop on early cut", pop_cnt, 3);
    chk("R9 no done on early cut", done_cnt, exp_done);
    expect_word(expw(ED), "R5 word D resent");
    session(8'h36, 1'b1, 32, 1'b1);
    exp_done++;
    chk("R5 pop after resend", pop_cnt, 4);

    // R6: 31 of 32 bits counts as taken
    session(8'h36, 1'b0, 31, 1'b0);
    exp_done++;
    chk("R6 31 bits of E", {1'b0, cur[30:0]}, {1'b0, expw(EE)[31:1]});
    chk("R6 pop on almost-full cut", pop_cnt, 5);
    chk("R9 done on almost-full cut", done_cnt, exp_done);
    expect_word(expw(EF), "R6 next word F");
    session(8'h36, 1'b1, 31, 1'b0);
    exp_done++;
    chk("R6 31 bits of F idle-high", {1'b0, cur[30:0]}, {1'b0, expw(EF)[31:1]});
    void'(exp_q.pop_front()); void'(tag_q.pop_front());
    chk("R6 pop F idle-high", pop_cnt, 6);

    // R8: other addresses are ignored
    ent_q.push_back(EG);
    hd(4);
    session(8'h35, 1'b0, 32, 1'b0);
    chk("R8 output zero for write address", cur, 32'd0);
    session(8'hB6, 1'b1, 32, 1'b0);
    chk("R8 output zero for near-miss address", cur, 32'd0);
    chk("R8 no pop on other address", pop_cnt, 6);
    chk("R9 no done on other address", done_cnt, exp_done);
    expect_word(expw(EG), "R8 word G still present");
    session(8'h36, 1'b0, 32, 1'b1);
    exp_done++;

    // R3/R4: buffer runs dry mid-period
    for (int k = 0; k < 5; k++) begin
      logic [27:0] e;
      e = {k[0], k[2:0], ~k[0], k[1:0], k[1], ~k[1], k[2:0] ^ 3'b101, 16'h1111 * (k + 1)};
      ent_q.push_back(e);
      expect_word(expw(e), "R3 burst word");
    end
    hd(4);
    session(8'h36, 1'b1, 176, 1'b1);
    exp_done++;
    chk("R4 zeros after dry buffer", {16'd0, cur[15:0]}, 32'd0);
    chk("R3 pops after burst", pop_cnt, 12);
    chk("R9 done after burst", done_cnt, exp_done);

    hd(20);
    chk("R3 all expected words seen", exp_q.size(), 0);
    chk("R11 output stable while clock high", stab_err, 0);
    summary();
    $finish;
  end

endmodule